// File: doc/BRIEF.md
# Scan Channel Sequencer with Per-Channel Gain Memory

This block drives the channel selection of a multiplexed analog front end. It holds a gain/reference code for every input channel, and it walks the multiplexer through a contiguous window of channels. The current position moves one step for each conversion-done pulse from the converter. For every conversion it presents the channel index, the gain index, a unipolar flag and a differential flag. The analog switching and the conversion itself sit outside the block.

The host configures the scan window with a single multiplexer-register write. The start channel goes in the low byte and the end channel in the high byte. If both fields name the same channel, that channel is selected alone, and a following range-register write stores its gain code. When the window start is numerically greater than the end, the scan runs through the top channel and continues from channel 0.

A channel marked differential uses its odd neighbour as the negative input, so the scan skips that neighbour. In the 16-channel variant each sample carries a channel tag, which lets a downstream reader detect dropped samples. The 32-channel variant provides no tag.

Top module: `scan_seq`

## Requirements
- R1: While reset is high, and in the cycle after it falls, the outputs are zero: cur_ch, gain_idx, unipolar and differential.
- R2: A cycle with mux_wr high loads the window. The start channel is mux_data[CH_W-1:0] and the end channel is mux_data[8+CH_W-1:8]; all other bits are ignored. After that clock edge, cur_ch equals the start channel and the gain fields show the stored code of that channel.
- R3: A range_wr cycle with start equal to end stores range_data as the code of that channel. The gain index is bits [3:0], bit 4 is unipolar and bit 5 is differential. The outputs do not change at that edge. The new code appears the next time the channel is presented.
- R4: A range_wr cycle with start not equal to end has no effect on any stored code.
- R5: On a conv_done cycle on a single-ended channel that is not the end channel, cur_ch advances by one after the edge. The gain fields show that channel's stored code.
- R6: On a conv_done cycle on the end channel, cur_ch returns to the start channel.
- R7: On a conv_done cycle on a differential channel, cur_ch advances by two, skipping the odd partner. If the partner is the end channel, cur_ch returns to the start channel instead.
- R8: The differential bit of a code written to an odd channel is discarded. An odd channel is always presented with differential low, and the scan steps past it by one.
- R9: Without mux_wr or conv_done, cur_ch and all gain fields hold their values. This holds across a range_wr.
- R10: Channel arithmetic wraps modulo NUM_CH, so a window with its start above its end scans through the top channel and on to channel 0.
- R11: With NUM_CH = 16, sample_tag equals cur_ch and tag_valid is 1. With NUM_CH = 32, both are 0.
- R12: If mux_wr and conv_done arrive in the same cycle, the window load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_wr | input | 1 | Multiplexer register write strobe |
| mux_data | input | 16 | Start channel (low byte), end channel (high byte) |
| range_wr | input | 1 | Range register write strobe |
| range_data | input | 8 | Range code: [3:0] gain index, [4] unipolar, [5] differential |
| conv_done | input | 1 | Conversion-done pulse, one cycle per conversion |
| cur_ch | output | CH_W | Channel presented to the converter |
| gain_idx | output | 4 | Gain index of the presented channel |
| unipolar | output | 1 | Unipolar range of the presented channel |
| differential | output | 1 | Differential input of the presented channel |
| sample_tag | output | 4 | Channel tag for the sample |
| tag_valid | output | 1 | The sample carries a channel tag |

## Verification
The hardest case to reach is a differential channel whose odd partner is the window end, because that is the case that forces an early wrap. The same applies to a window that straddles the top channel, because the double step must then wrap modulo the channel count. The stimulus first programs every channel's code through single-channel selections. It then opens windows 13..15 and 14..1 so that the differential channel 14 meets both cases. A differential bit written to odd channel 7 and an ignored range write during a multi-channel window are both observed later, when the scan passes over the channels involved.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef struct packed {
    logic       diff;
    logic       uni;
    logic [3:0] gain;
  } gcode_t;

  // Split a raw range byte into fields; odd channels cannot be differential.
  function automatic gcode_t decode_code(input logic [7:0] raw, input logic odd);
    gcode_t c;
    c.gain = raw[3:0];
    c.uni  = raw[4];
    c.diff = raw[5] & ~odd;
    return c;
  endfunction

endpackage

// File: rtl/scan_gain_mem.sv
module scan_gain_mem
  import scan_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  gcode_t        wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output gcode_t        rdata
);

  gcode_t mem [DEPTH];

  // Write port, no reset on the array so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with enable; read-first on address collision.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/scan_step.sv
module scan_step #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [CH_W-1:0] cur,
  input  logic [CH_W-1:0] start_ch,
  input  logic [CH_W-1:0] end_ch,
  input  logic            cur_diff,
  output logic [CH_W-1:0] nxt
);

  logic [CH_W-1:0] plus1, plus2;

  always_comb begin
    plus1 = cur + CH_W'(1);
    plus2 = cur + CH_W'(2);
    if (cur == end_ch)                     nxt = start_ch;
    else if (cur_diff && (plus1 == end_ch)) nxt = start_ch;
    else if (cur_diff)                     nxt = plus2;
    else                                   nxt = plus1;
  end

endmodule

// File: rtl/scan_tag.sv
module scan_tag #(
  parameter int NUM_CH = 16,
  parameter int TAG_W  = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [CH_W-1:0]  cur,
  output logic [TAG_W-1:0] tag,
  output logic             tag_valid
);

  generate
    if (CH_W <= TAG_W) begin : g_tagged
      assign tag       = TAG_W'(cur);
      assign tag_valid = 1'b1;
    end else begin : g_untagged
      assign tag       = '0;
      assign tag_valid = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TAG_W  = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mux_wr,
  input  logic [15:0]      mux_data,
  input  logic             range_wr,
  input  logic [7:0]       range_data,
  input  logic             conv_done,
  output logic [CH_W-1:0]  cur_ch,
  output logic [3:0]       gain_idx,
  output logic             unipolar,
  output logic             differential,
  output logic [TAG_W-1:0] sample_tag,
  output logic             tag_valid
);

  logic [CH_W-1:0] start_q, end_q, cur_q;
  logic [CH_W-1:0] nxt_ch, raddr, mux_start, mux_end;
  logic            single_sel, mem_we, mem_re;
  gcode_t          wcode, rcode;

  assign mux_start  = mux_data[CH_W-1:0];
  assign mux_end    = mux_data[8 +: CH_W];
  assign single_sel = (start_q == end_q);

  // Gain memory write: only when a single channel is selected.
  assign mem_we = range_wr && single_sel;
  assign wcode  = decode_code(range_data, start_q[0]);

  // Read the entry for whatever channel is presented next.
  assign mem_re = mux_wr || conv_done;
  assign raddr  = mux_wr ? mux_start : nxt_ch;

  scan_step #(.NUM_CH(NUM_CH)) step_i (
    .cur      (cur_q),
    .start_ch (start_q),
    .end_ch   (end_q),
    .cur_diff (rcode.diff),
    .nxt      (nxt_ch)
  );

  scan_gain_mem #(.DEPTH(NUM_CH)) mem_i (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .waddr (start_q),
    .wdata (wcode),
    .re    (mem_re),
    .raddr (raddr),
    .rdata (rcode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      cur_q   <= '0;
    end else if (mux_wr) begin
      start_q <= mux_start;
      end_q   <= mux_end;
      cur_q   <= mux_start;
    end else if (conv_done) begin
      cur_q   <= nxt_ch;
    end
  end

  assign cur_ch       = cur_q;
  assign gain_idx     = rcode.gain;
  assign unipolar     = rcode.uni;
  assign differential = rcode.diff;

  scan_tag #(.NUM_CH(NUM_CH), .TAG_W(TAG_W)) tag_i (
    .cur       (cur_q),
    .tag       (sample_tag),
    .tag_valid (tag_valid)
  );

  // R2
  mux_load_chk: assert property (@(posedge clk) disable iff (rst)
    mux_wr |=> cur_ch == $past(mux_start));

  // R6
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !mux_wr && cur_q == end_q) |=> cur_ch == $past(start_q));

  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !mux_wr && cur_q != end_q && !differential)
      |=> cur_ch == CH_W'($past(cur_q) + CH_W'(1)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!conv_done && !mux_wr)
      |=> ($stable(cur_ch) && $stable(gain_idx) && $stable(unipolar) && $stable(differential)));

  // R8
  diff_even_chk: assert property (@(posedge clk) disable iff (rst)
    differential |-> !cur_ch[0]);

endmodule

// File: tb/scan_seq_tb.sv
module scan_seq_tb_top;

  localparam int NUM_CH = 16;
  localparam int CH_W   = 4;
  localparam logic [1:0] NOP = 2'd0, MUX = 2'd1, RNG = 2'd2, CNV = 2'd3;

  // {op, data, expected channel}
  localparam logic [25:0] VEC [20] = '{
    {MUX, 16'h0502, 8'd2},  {CNV, 16'h0000, 8'd3},  {CNV, 16'h0000, 8'd4},
    {CNV, 16'h0000, 8'd2},  {CNV, 16'h0000, 8'd3},  {RNG, 16'h003F, 8'd3},
    {CNV, 16'h0000, 8'd4},  {CNV, 16'h0000, 8'd2},  {MUX, 16'h0F0D, 8'd13},
    {CNV, 16'h0000, 8'd14}, {CNV, 16'h0000, 8'd13}, {MUX, 16'h010E, 8'd14},
    {CNV, 16'h0000, 8'd0},  {CNV, 16'h0000, 8'd1},  {CNV, 16'h0000, 8'd14},
    {MUX, 16'h0806, 8'd6},  {CNV, 16'h0000, 8'd7},  {CNV, 16'h0000, 8'd8},
    {CNV, 16'h0000, 8'd6},  {NOP, 16'h0000, 8'd6}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic mux_wr = 1'b0, range_wr = 1'b0, conv_done = 1'b0;
  logic [15:0] mux_data = '0;
  logic [7:0]  range_data = '0;
  logic [CH_W-1:0] cur_ch;
  logic [3:0] gain_idx, sample_tag;
  logic unipolar, differential, tag_valid;
  int checks = 0, errors = 0, cycles = 0;
  logic [5:0] ch3_code = 6'h13;

  always #10 clk = ~clk;

  scan_seq #(.NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst(rst), .mux_wr(mux_wr), .mux_data(mux_data),
    .range_wr(range_wr), .range_data(range_data), .conv_done(conv_done),
    .cur_ch(cur_ch), .gain_idx(gain_idx), .unipolar(unipolar),
    .differential(differential), .sample_tag(sample_tag), .tag_valid(tag_valid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Raw range byte programmed per channel
  function automatic logic [7:0] raw_code(input int c);
    logic [7:0] r;
    r = 8'(c & 7);
    if (c == 3 || c == 9) r[4] = 1'b1;
    if (c == 4 || c == 14 || c == 7) r[5] = 1'b1;
    return r;
  endfunction

  // Expected {diff, uni, gain}; odd diff bits dropped (R8)
  function automatic logic [5:0] exp_code(input int c);
    logic [7:0] r;
    r = raw_code(c);
    if (c == 3) return ch3_code;
    return {r[5] & ~r[0], r[4], r[3:0]};
  endfunction

  task automatic op(input logic [1:0] k, input logic [15:0] d);
    @(negedge clk);
    mux_wr     = (k == MUX);
    range_wr   = (k == RNG);
    conv_done  = (k == CNV);
    mux_data   = d;
    range_data = d[7:0];
    @(negedge clk);
    mux_wr = 1'b0; range_wr = 1'b0; conv_done = 1'b0;
  endtask

  task automatic check(input string req, input int ech, input logic [5:0] ecode);
    logic [5:0] act;
    act = {differential, unipolar, gain_idx};
    checks++;
    if (int'(cur_ch) != ech || act != ecode) begin
      errors++;
      $display("FAIL %s: actual ch=%0d code=%h expected ch=%0d code=%h", req, cur_ch, act, ech, ecode);
    end
    checks++;
    if (sample_tag != 4'(ech) || tag_valid != 1'b1) begin // R11
      errors++;
      $display("FAIL R11: actual tag=%0d v=%0b expected tag=%0d v=1", sample_tag, tag_valid, ech);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, 6'h00);            // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check("R1", 0, 6'h00);            // R1 after release

    // Program every channel through single-channel selections (R3)
    for (int c = 0; c < NUM_CH; c++) begin
      op(MUX, {8'(c), 8'(c)});
      op(RNG, {8'h00, raw_code(c)});
    end

    // Table walk: R2 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 20; i++) begin
      op(VEC[i][25:24], VEC[i][23:8]);
      check($sformatf("R5 R6 R7 R10 row %0d", i), int'(VEC[i][7:0]), exp_code(int'(VEC[i][7:0])));
    end

    // R12: load and step in the same cycle, load wins
    @(negedge clk);
    mux_wr = 1'b1; conv_done = 1'b1; mux_data = 16'h0303;
    @(negedge clk);
    mux_wr = 1'b0; conv_done = 1'b0;
    check("R12", 3, exp_code(3));

    // R3: new code held back until the channel is presented again
    op(RNG, 16'h0015);
    check("R3 hold", 3, exp_code(3));
    ch3_code = 6'h15;
    op(CNV, 16'h0000);
    check("R3", 3, exp_code(3));

    // R2: bits above the channel field are ignored
    op(MUX, 16'hE1E1);
    check("R2", 1, exp_code(1));

    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 rerun", 0, 6'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule